// File: doc/BRIEF.md
# Dual-Bank Flash Command Interpreter

This block is the command front end of a two-bank, word-wide flash array. Software issues command cycles, each a bank/block address and an 8-bit command code. The block decodes single-cycle and two-cycle commands separately for each bank. It decides what a read from each bank returns: array contents, that bank's status register, or a small query table. Each bank has its own status flags, its own read mode and its own erase engine. A command therefore affects only the bank it addresses, and both banks can erase at the same time.

An erase engine spends a parameter number of clock cycles (`ERASE_CYC`) on each block. It then fills that block of the array model with ones. A bank erase walks every block of the bank. A protected block is skipped in one cycle and flagged. A low programming voltage at confirm time rejects the erase at once. A busy bank can be suspended and resumed, and pulling the reset pin low abandons any erase.

Top module: `flash_cmd_dualbank`

## Requirements
- R1: After reset, both banks read array data, status reads 0x0080, and every array word holds 0xC000 OR its word address. A reset during an erase abandons it.
- R2: Command FFh selects array reads and 70h selects status reads for the addressed bank, both in idle and in suspended state.
- R3: Command 98h written to bank 0 makes bank 0 reads return the query table, indexed by the word offset inside the bank: 0→0x0051, 1→0x0052, 2→0x0059, 3→blocks per bank, 4→words per block, 5→`ERASE_CYC`, others 0. Written to bank 1, 98h is ignored.
- R4: Command 50h clears status bits 5, 4, 3 and 1 of the addressed bank only, whatever `vpp_ok` is, and returns that bank to array reads.
- R5: Block erase is 20h followed by D0h, with the block given in the first cycle. Exactly `ERASE_CYC` cycles after the confirm edge the block reads all 0xFFFF, and the other blocks keep their contents.
- R6: Bank erase is 80h followed by D0h. It erases every unprotected block of the bank in order, taking `ERASE_CYC` cycles per unprotected block and 1 cycle per protected block.
- R7: If the cycle after 20h or 80h is not D0h, the bank sets status bits 4 and 5, erases nothing and returns to idle.
- R8: From the first erase cycle on, every address in the bank reads the status register. This stays true after the erase ends, until FFh is written.
- R9: Status bit 7 reads 0 while a bank is erasing and 1 otherwise, including while it is suspended.
- R10: A protected block (`blk_prot` bit bank*blocks+block) sets status bits 1 and 5 and keeps its contents. If `vpp_ok` is low at confirm, bits 3 and 5 are set and the erase is rejected without a busy cycle.
- R11: While a bank is erasing, only 70h and B0h are acted on; every other code written to that bank is ignored.
- R12: B0h suspends a busy bank and sets status bit 6. The cycle counter holds, and D0h resumes from the held count, so the active cycles still total `ERASE_CYC` per block. A B0h arriving on the last cycle of an erase has no effect.
- R13: Driving `rst_n` low during an erase stops it: the bank reads array data with status 0x0080 afterwards.
- R14: A command to one bank leaves the other bank's read mode, status and erase progress unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; aborts erases |
| cmd_en | input | 1 | A command cycle is present this clock |
| cmd_addr | input | CMD_AW | Bank (MSB) and block of the command cycle |
| cmd_code | input | 8 | Command code |
| vpp_ok | input | 1 | Programming voltage above lockout |
| blk_prot | input | 2*BLK_PER_BANK | Per-block protect bits, bank-major |
| rd_addr | input | RD_AW | Read word address: bank, block, word |
| rd_data | output | 16 | Read data for `rd_addr` under that bank's read mode |

## Verification
The assertions assume that each command occupies one clock with `cmd_en` high and that `cmd_addr` and `cmd_code` are steady around the rising edge. They also take `blk_prot` to be a static configuration while an erase walks its blocks. The bench drives every input on the falling edge, moves `vpp_ok` and `blk_prot` only while the banks involved are idle, and never issues B0h on the final cycle of an erase, so the observed results do not depend on that corner. A behavioural model in the bench predicts `rd_data` on every cycle, and directed reads check the hand-computed values each requirement names.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

   typedef enum logic [1:0] {
      RM_ARRAY  = 2'd0,
      RM_STATUS = 2'd1,
      RM_QUERY  = 2'd2
   } rd_mode_e;

   typedef enum logic [2:0] {
      BS_IDLE     = 3'd0,
      BS_ARM_BLK  = 3'd1,
      BS_ARM_BANK = 3'd2,
      BS_BUSY     = 3'd3,
      BS_HOLD     = 3'd4
   } bank_st_e;

   localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
   localparam logic [7:0] OP_READ_STAT  = 8'h70;
   localparam logic [7:0] OP_QUERY      = 8'h98;
   localparam logic [7:0] OP_CLEAR      = 8'h50;
   localparam logic [7:0] OP_BLK_SETUP  = 8'h20;
   localparam logic [7:0] OP_BANK_SETUP = 8'h80;
   localparam logic [7:0] OP_CONFIRM    = 8'hD0;
   localparam logic [7:0] OP_SUSPEND    = 8'hB0;

   localparam int SB_READY = 7;
   localparam int SB_SUSP  = 6;
   localparam int SB_EFAIL = 5;
   localparam int SB_SEQ   = 4;
   localparam int SB_VLOW  = 3;
   localparam int SB_PROT  = 1;

   localparam logic [15:0] FILL_BASE = 16'hC000;

   function automatic logic [15:0] query_word(input int unsigned idx,
                                              input int unsigned blks,
                                              input int unsigned words,
                                              input int unsigned cyc);
      case (idx)
         0:       return 16'h0051;
         1:       return 16'h0052;
         2:       return 16'h0059;
         3:       return 16'(blks);
         4:       return 16'(words);
         5:       return 16'(cyc);
         default: return 16'h0000;
      endcase
   endfunction

endpackage

// File: rtl/fcmd_bank_ctrl.sv
module fcmd_bank_ctrl
   import fcmd_pkg::*;
#(
   parameter int BLK_PER_BANK = 4,
   parameter int ERASE_CYC    = 20,
   parameter bit QUERY_EN     = 1'b0,
   localparam int BLK_W       = $clog2(BLK_PER_BANK)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sel,
   input  logic [7:0]              op,
   input  logic [BLK_W-1:0]        op_blk,
   input  logic                    vpp_ok,
   input  logic [BLK_PER_BANK-1:0] prot,
   output rd_mode_e                mode,
   output logic [7:0]              status,
   output logic                    wipe_en,
   output logic [BLK_W-1:0]        wipe_blk
);

   localparam int CNT_W = $clog2(ERASE_CYC);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ERASE_CYC - 1);
   localparam logic [BLK_W-1:0] TOP_BLK  = BLK_W'(BLK_PER_BANK - 1);

   bank_st_e         st;
   logic [BLK_W-1:0] tgt_blk, cur_blk, last_blk;
   logic [CNT_W-1:0] cnt;
   logic             f_efail, f_seq, f_vlow, f_prot;
   logic             blk_done, op_done;

   always_comb begin
      blk_done = 1'b0;
      op_done  = 1'b0;
      if (st == BS_BUSY) begin
         blk_done = prot[cur_blk] || (cnt == LAST_CNT);
         op_done  = blk_done && (cur_blk == last_blk);
      end
   end

   assign wipe_en  = (st == BS_BUSY) && !prot[cur_blk] && (cnt == LAST_CNT);
   assign wipe_blk = cur_blk;

   assign status = {(st != BS_BUSY), (st == BS_HOLD), f_efail, f_seq,
                    f_vlow, 1'b0, f_prot, 1'b0};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= BS_IDLE;
         mode     <= RM_ARRAY;
         tgt_blk  <= '0;
         cur_blk  <= '0;
         last_blk <= '0;
         cnt      <= '0;
         f_efail  <= 1'b0;
         f_seq    <= 1'b0;
         f_vlow   <= 1'b0;
         f_prot   <= 1'b0;
      end else begin
         case (st)
            BS_IDLE: begin
               if (sel) begin
                  case (op)
                     OP_READ_ARRAY: mode <= RM_ARRAY;
                     OP_READ_STAT:  mode <= RM_STATUS;
                     OP_QUERY: begin
                        if (QUERY_EN) mode <= RM_QUERY;
                     end
                     OP_CLEAR: begin
                        f_efail <= 1'b0;
                        f_seq   <= 1'b0;
                        f_vlow  <= 1'b0;
                        f_prot  <= 1'b0;
                        mode    <= RM_ARRAY;
                     end
                     OP_BLK_SETUP: begin
                        st      <= BS_ARM_BLK;
                        tgt_blk <= op_blk;
                        mode    <= RM_STATUS;
                     end
                     OP_BANK_SETUP: begin
                        st   <= BS_ARM_BANK;
                        mode <= RM_STATUS;
                     end
                     default: ;
                  endcase
               end
            end
            BS_ARM_BLK, BS_ARM_BANK: begin
               if (sel) begin
                  if (op != OP_CONFIRM) begin
                     f_seq   <= 1'b1;
                     f_efail <= 1'b1;
                     st      <= BS_IDLE;
                  end else if (!vpp_ok) begin
                     f_vlow  <= 1'b1;
                     f_efail <= 1'b1;
                     st      <= BS_IDLE;
                  end else begin
                     st       <= BS_BUSY;
                     cnt      <= '0;
                     cur_blk  <= (st == BS_ARM_BLK) ? tgt_blk : '0;
                     last_blk <= (st == BS_ARM_BLK) ? tgt_blk : TOP_BLK;
                  end
               end
            end
            BS_BUSY: begin
               if (prot[cur_blk]) begin
                  f_prot  <= 1'b1;
                  f_efail <= 1'b1;
               end
               if (blk_done) begin
                  cnt <= '0;
                  if (cur_blk == last_blk) st <= BS_IDLE;
                  else                     cur_blk <= cur_blk + BLK_W'(1);
               end else begin
                  cnt <= cnt + CNT_W'(1);
               end
               if (!op_done && sel && op == OP_SUSPEND) st <= BS_HOLD;
            end
            BS_HOLD: begin
               if (sel) begin
                  case (op)
                     OP_READ_ARRAY: mode <= RM_ARRAY;
                     OP_READ_STAT:  mode <= RM_STATUS;
                     OP_QUERY: begin
                        if (QUERY_EN) mode <= RM_QUERY;
                     end
                     OP_CONFIRM: begin
                        st   <= BS_BUSY;
                        mode <= RM_STATUS;
                     end
                     default: ;
                  endcase
               end
            end
            default: st <= BS_IDLE;
         endcase
      end
   end

   AST_CONFIRM_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BS_BUSY && $past(st) != BS_BUSY) |-> $past(sel && op == OP_CONFIRM)); // R5

   AST_BUSY_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BS_BUSY && sel && op != OP_READ_STAT && op != OP_SUSPEND) |=> (mode == $past(mode))); // R11

   AST_CLEAR_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BS_IDLE && sel && op == OP_CLEAR) |=>
         (mode == RM_ARRAY && status[5:3] == 3'b000 && !status[1])); // R4

   AST_BAD_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == BS_ARM_BLK || st == BS_ARM_BANK) && sel && op != OP_CONFIRM) |=>
         (st == BS_IDLE && status[SB_SEQ] && status[SB_EFAIL])); // R7

   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BS_HOLD) |=> (cnt == $past(cnt) && cur_blk == $past(cur_blk))); // R12

   AST_READY_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BS_HOLD) |-> (status[SB_READY] && status[SB_SUSP])); // R9

   if (!QUERY_EN) begin : g_no_query
      AST_QUERY_BANK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
         mode != RM_QUERY); // R3
   end

endmodule

// File: rtl/fcmd_array.sv
module fcmd_array
   import fcmd_pkg::*;
#(
   parameter int BLK_PER_BANK  = 4,
   parameter int WORDS_PER_BLK = 8,
   localparam int BLK_W        = $clog2(BLK_PER_BANK),
   localparam int WRD_W        = $clog2(WORDS_PER_BLK),
   localparam int RD_AW        = 1 + BLK_W + WRD_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            wipe_en,
   input  logic [1:0][BLK_W-1:0] wipe_blk,
   input  logic [RD_AW-1:0]      rd_addr,
   output logic [15:0]           rd_word
);

   localparam int NWORDS = 2 ** RD_AW;

   logic [15:0] mem [NWORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NWORDS; i++) mem[i] <= FILL_BASE | 16'(i);
      end else begin
         for (int b = 0; b < 2; b++) begin
            if (wipe_en[b]) begin
               for (int w = 0; w < WORDS_PER_BLK; w++)
                  mem[{1'(b), wipe_blk[b], WRD_W'(w)}] <= 16'hFFFF;
            end
         end
      end
   end

   assign rd_word = mem[rd_addr];

endmodule

// File: rtl/fcmd_read_sel.sv
module fcmd_read_sel
   import fcmd_pkg::*;
#(
   parameter int BLK_PER_BANK  = 4,
   parameter int WORDS_PER_BLK = 8,
   parameter int ERASE_CYC     = 20,
   localparam int RD_AW        = 1 + $clog2(BLK_PER_BANK) + $clog2(WORDS_PER_BLK)
) (
   input  logic [RD_AW-1:0] rd_addr,
   input  logic [15:0]      arr_word,
   input  rd_mode_e         bank_mode [2],
   input  logic [7:0]       bank_stat [2],
   output logic [15:0]      rd_data
);

   logic     bank;
   rd_mode_e cur_mode;

   assign bank     = rd_addr[RD_AW-1];
   assign cur_mode = bank_mode[bank];

   always_comb begin
      case (cur_mode)
         RM_STATUS: rd_data = {8'h00, bank_stat[bank]};
         RM_QUERY:  rd_data = query_word(int'(rd_addr[RD_AW-2:0]), BLK_PER_BANK,
                                         WORDS_PER_BLK, ERASE_CYC);
         default:   rd_data = arr_word;
      endcase
   end

endmodule

// File: rtl/flash_cmd_dualbank.sv
module flash_cmd_dualbank
   import fcmd_pkg::*;
#(
   parameter int BLK_PER_BANK  = 4,
   parameter int WORDS_PER_BLK = 8,
   parameter int ERASE_CYC     = 20,
   parameter int CMD_AW        = 1 + $clog2(BLK_PER_BANK),
   parameter int RD_AW         = 1 + $clog2(BLK_PER_BANK) + $clog2(WORDS_PER_BLK)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cmd_en,
   input  logic [CMD_AW-1:0]         cmd_addr,
   input  logic [7:0]                cmd_code,
   input  logic                      vpp_ok,
   input  logic [2*BLK_PER_BANK-1:0] blk_prot,
   input  logic [RD_AW-1:0]          rd_addr,
   output logic [15:0]               rd_data
);

   localparam int NBANK = 2;
   localparam int BLK_W = $clog2(BLK_PER_BANK);

   if (BLK_PER_BANK < 2 || (1 << BLK_W) != BLK_PER_BANK) begin : g_chk_blk
      $error("BLK_PER_BANK must be a power of two, at least 2");
   end
   if (WORDS_PER_BLK < 8 || (1 << $clog2(WORDS_PER_BLK)) != WORDS_PER_BLK) begin : g_chk_wrd
      $error("WORDS_PER_BLK must be a power of two, at least 8");
   end
   if (ERASE_CYC < 2 || ERASE_CYC > 65535) begin : g_chk_cyc
      $error("ERASE_CYC must lie in 2..65535");
   end
   if (CMD_AW != 1 + BLK_W || RD_AW > 12) begin : g_chk_aw
      $error("address widths do not match the geometry");
   end

   rd_mode_e              bank_mode [NBANK];
   logic [7:0]            bank_stat [NBANK];
   logic [NBANK-1:0]      bank_sel;
   logic [NBANK-1:0]      wipe_en;
   logic [NBANK-1:0][BLK_W-1:0] wipe_blk;
   logic [15:0]           arr_word;

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      assign bank_sel[g] = cmd_en && (cmd_addr[CMD_AW-1] == 1'(g));

      fcmd_bank_ctrl #(
         .BLK_PER_BANK (BLK_PER_BANK),
         .ERASE_CYC    (ERASE_CYC),
         .QUERY_EN     (g == 0)
      ) u_ctrl (
         .clk      (clk),
         .rst_n    (rst_n),
         .sel      (bank_sel[g]),
         .op       (cmd_code),
         .op_blk   (cmd_addr[BLK_W-1:0]),
         .vpp_ok   (vpp_ok),
         .prot     (blk_prot[g*BLK_PER_BANK +: BLK_PER_BANK]),
         .mode     (bank_mode[g]),
         .status   (bank_stat[g]),
         .wipe_en  (wipe_en[g]),
         .wipe_blk (wipe_blk[g])
      );
   end

   fcmd_array #(
      .BLK_PER_BANK  (BLK_PER_BANK),
      .WORDS_PER_BLK (WORDS_PER_BLK)
   ) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .wipe_en  (wipe_en),
      .wipe_blk (wipe_blk),
      .rd_addr  (rd_addr),
      .rd_word  (arr_word)
   );

   fcmd_read_sel #(
      .BLK_PER_BANK  (BLK_PER_BANK),
      .WORDS_PER_BLK (WORDS_PER_BLK),
      .ERASE_CYC     (ERASE_CYC)
   ) u_rsel (
      .rd_addr   (rd_addr),
      .arr_word  (arr_word),
      .bank_mode (bank_mode),
      .bank_stat (bank_stat),
      .rd_data   (rd_data)
   );

   AST_BANK0_ISOLATION: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_en && !cmd_addr[CMD_AW-1]) |=> (bank_mode[1] == $past(bank_mode[1]))); // R14

   AST_BANK1_ISOLATION: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_en && cmd_addr[CMD_AW-1]) |=> (bank_mode[0] == $past(bank_mode[0]))); // R14

endmodule

// File: tb/tb_flash_cmd_dualbank.sv
`timescale 1ns/1ps
module tb_flash_cmd_dualbank;

   localparam int BPB = 4;
   localparam int WPB = 8;
   localparam int EC  = 20;
   localparam int BW  = 2;
   localparam int CAW = 1 + BW;
   localparam int RAW = 1 + BW + 3;
   localparam int BANKW = BPB * WPB;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_en = 1'b0;
   logic [CAW-1:0]   cmd_addr = '0;
   logic [7:0]       cmd_code = 8'h00;
   logic             vpp_ok = 1'b1;
   logic [2*BPB-1:0] blk_prot = '0;
   logic [RAW-1:0]   rd_addr = '0;
   logic [15:0]      rd_data;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";

   always #4 clk = ~clk;

   flash_cmd_dualbank #(.BLK_PER_BANK(BPB), .WORDS_PER_BLK(WPB), .ERASE_CYC(EC)) dut (
      .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_addr(cmd_addr),
      .cmd_code(cmd_code), .vpp_ok(vpp_ok), .blk_prot(blk_prot),
      .rd_addr(rd_addr), .rd_data(rd_data));

   // behavioural reference: 0 array, 1 status, 2 query; states 0 idle, 1/2 armed, 3 busy, 4 held
   int m_mem [2*BANKW];
   int m_mode [2], m_st [2], m_tgt [2], m_cur [2], m_last [2], m_cnt [2];
   int m_ef [2], m_sq [2], m_vl [2], m_pr [2];

   task automatic m_reset();
      for (int i = 0; i < 2*BANKW; i++) m_mem[i] = 'hC000 + i;
      for (int b = 0; b < 2; b++) begin
         m_mode[b] = 0; m_st[b] = 0; m_tgt[b] = 0; m_cur[b] = 0; m_last[b] = 0;
         m_cnt[b] = 0; m_ef[b] = 0; m_sq[b] = 0; m_vl[b] = 0; m_pr[b] = 0;
      end
   endtask

   function automatic int m_status(int b);
      return (m_st[b] == 3 ? 0 : 128) + (m_st[b] == 4 ? 64 : 0) + 32*m_ef[b]
           + 16*m_sq[b] + 8*m_vl[b] + 2*m_pr[b];
   endfunction

   function automatic int m_read(int a);
      int b = a / BANKW;
      int off = a % BANKW;
      if (m_mode[b] == 1) return m_status(b);
      if (m_mode[b] == 2) begin
         case (off)
            0: return 'h51; 1: return 'h52; 2: return 'h59;
            3: return BPB;  4: return WPB;  5: return EC;
            default: return 0;
         endcase
      end
      return m_mem[a];
   endfunction

   task automatic m_step();
      for (int b = 0; b < 2; b++) begin
         bit s = cmd_en && (int'(cmd_addr) / BPB == b);
         int c = int'(cmd_code);
         case (m_st[b])
            0: if (s) begin
               if (c == 'hFF) m_mode[b] = 0;
               else if (c == 'h70) m_mode[b] = 1;
               else if (c == 'h98) begin if (b == 0) m_mode[b] = 2; end
               else if (c == 'h50) begin m_ef[b] = 0; m_sq[b] = 0; m_vl[b] = 0; m_pr[b] = 0; m_mode[b] = 0; end
               else if (c == 'h20) begin m_st[b] = 1; m_tgt[b] = int'(cmd_addr) % BPB; m_mode[b] = 1; end
               else if (c == 'h80) begin m_st[b] = 2; m_mode[b] = 1; end
            end
            1, 2: if (s) begin
               if (c != 'hD0) begin m_sq[b] = 1; m_ef[b] = 1; m_st[b] = 0; end
               else if (!vpp_ok) begin m_vl[b] = 1; m_ef[b] = 1; m_st[b] = 0; end
               else begin
                  m_cur[b]  = (m_st[b] == 1) ? m_tgt[b] : 0;
                  m_last[b] = (m_st[b] == 1) ? m_tgt[b] : BPB - 1;
                  m_cnt[b] = 0; m_st[b] = 3;
               end
            end
            3: begin
               bit done = 0;
               bit fin = 0;
               if (blk_prot[b*BPB + m_cur[b]]) begin m_pr[b] = 1; m_ef[b] = 1; done = 1; end
               else if (m_cnt[b] == EC - 1) begin
                  for (int w = 0; w < WPB; w++) m_mem[b*BANKW + m_cur[b]*WPB + w] = 'hFFFF;
                  done = 1;
               end else m_cnt[b]++;
               if (done) begin
                  m_cnt[b] = 0;
                  if (m_cur[b] == m_last[b]) begin m_st[b] = 0; fin = 1; end
                  else m_cur[b]++;
               end
               if (!fin && s && c == 'hB0) m_st[b] = 4;
            end
            4: if (s) begin
               if (c == 'hFF) m_mode[b] = 0;
               else if (c == 'h70) m_mode[b] = 1;
               else if (c == 'h98) begin if (b == 0) m_mode[b] = 2; end
               else if (c == 'hD0) begin m_st[b] = 3; m_mode[b] = 1; end
            end
            default: ;
         endcase
      end
   endtask

   task automatic chk(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: rd_data=%04h expected %04h at %0t", req, got, exp, $time);
      end
   endtask

   // lockstep comparison on every clock
   always @(posedge clk) begin
      if (!rst_n) m_reset();
      else m_step();
      #2;
      if (rst_n) chk({cur_req, " lockstep"}, int'(rd_data), m_read(int'(rd_addr)));
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   task automatic wr(int b, int blk, int code);
      @(negedge clk);
      cmd_en = 1'b1; cmd_addr = CAW'(b*BPB + blk); cmd_code = 8'(code);
      @(negedge clk);
      cmd_en = 1'b0;
   endtask

   task automatic rdc(string req, int b, int blk, int w, int exp);
      @(negedge clk);
      rd_addr = RAW'(b*BANKW + blk*WPB + w);
      #1;
      chk(req, int'(rd_data), exp);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;

      cur_req = "R1";
      rdc("R1 reset pattern", 0, 0, 0, 'hC000);
      rdc("R1 reset pattern", 1, 3, 7, 'hC03F);
      cur_req = "R2";
      wr(0, 0, 'h70);
      rdc("R2 status read", 0, 1, 1, 'h0080);
      wr(0, 0, 'hFF);
      rdc("R2 array read", 0, 1, 1, 'hC009);

      cur_req = "R3";
      wr(0, 0, 'h98);
      rdc("R3 query 0", 0, 0, 0, 'h0051);
      rdc("R3 query 2", 0, 0, 2, 'h0059);
      rdc("R3 query 5", 0, 0, 5, EC);
      rdc("R3 other bank array", 1, 0, 1, 'hC021);
      wr(1, 0, 'h98);
      rdc("R3 bank1 ignores query", 1, 0, 0, 'hC020);
      wr(0, 0, 'hFF);
      rdc("R3 back to array", 0, 0, 0, 'hC000);

      cur_req = "R7";
      wr(0, 1, 'h20);
      rdc("R8 status after setup", 0, 0, 0, 'h0080);
      wr(0, 1, 'h55);
      rdc("R7 bad confirm", 0, 2, 2, 'h00B0);
      wr(1, 0, 'h80);
      wr(1, 0, 'h20);
      rdc("R7 bad confirm bank1", 1, 0, 0, 'h00B0);

      cur_req = "R4";
      vpp_ok = 1'b0;
      wr(0, 0, 'h50);
      rdc("R4 clear returns array", 0, 1, 0, 'hC008);
      wr(0, 0, 'h70);
      rdc("R4 cleared bits", 0, 1, 0, 'h0080);
      rdc("R14 other bank flags kept", 1, 0, 0, 'h00B0);
      wr(1, 0, 'h50);
      rdc("R4 clear bank1", 1, 0, 0, 'hC020);
      vpp_ok = 1'b1;

      cur_req = "R5";
      wr(0, 2, 'h20);
      wr(0, 2, 'hD0);
      rdc("R9 busy bit low", 0, 0, 3, 'h0000);
      idle(25);
      rdc("R8 status persists", 0, 3, 3, 'h0080);
      wr(0, 0, 'hFF);
      rdc("R5 block erased", 0, 2, 5, 'hFFFF);
      rdc("R5 neighbour kept", 0, 1, 5, 'hC00D);
      rdc("R5 neighbour kept", 0, 3, 0, 'hC018);

      cur_req = "R11";
      wr(0, 3, 'h20);
      wr(0, 3, 'hD0);
      wr(0, 0, 'hFF);
      wr(0, 0, 'h50);
      wr(0, 0, 'h98);
      rdc("R11 busy ignores FF/50/98", 0, 0, 0, 'h0000);
      wr(0, 0, 'h70);
      rdc("R11 status read while busy", 0, 0, 0, 'h0000);
      idle(25);
      rdc("R9 ready after erase", 0, 3, 0, 'h0080);
      wr(0, 0, 'hFF);
      rdc("R11 erase completed", 0, 3, 1, 'hFFFF);

      cur_req = "R12";
      wr(1, 0, 'h20);
      wr(1, 0, 'hD0);
      idle(5);
      wr(1, 0, 'hB0);
      rdc("R12 suspended", 1, 0, 0, 'h00C0);
      idle(40);
      rdc("R12 stays suspended", 1, 0, 0, 'h00C0);
      wr(1, 0, 'hFF);
      rdc("R2 array read while held", 1, 0, 0, 'hC020);
      wr(1, 0, 'hD0);
      rdc("R12 resumed busy", 1, 0, 0, 'h0000);
      idle(20);
      rdc("R12 finished", 1, 0, 0, 'h0080);
      wr(1, 0, 'hFF);
      rdc("R12 block erased", 1, 0, 7, 'hFFFF);
      rdc("R12 neighbour kept", 1, 1, 0, 'hC028);

      cur_req = "R10";
      blk_prot = 8'b0010_0000;
      wr(1, 1, 'h20);
      wr(1, 1, 'hD0);
      idle(3);
      rdc("R10 protected flags", 1, 1, 0, 'h00A2);
      wr(1, 0, 'hFF);
      rdc("R10 protected kept", 1, 1, 0, 'hC028);
      wr(1, 0, 'h50);
      vpp_ok = 1'b0;
      wr(1, 2, 'h20);
      wr(1, 2, 'hD0);
      rdc("R10 low voltage flags", 1, 2, 0, 'h00A8);
      wr(1, 0, 'hFF);
      rdc("R10 low voltage kept", 1, 2, 0, 'hC030);
      wr(1, 0, 'h50);
      vpp_ok = 1'b1;

      cur_req = "R6";
      wr(1, 0, 'h80);
      wr(1, 3, 'hD0);
      wr(0, 0, 'h70);
      rdc("R14 bank0 status during bank1 erase", 0, 0, 0, 'h0080);
      wr(0, 0, 'hFF);
      rdc("R14 bank0 array during bank1 erase", 0, 0, 1, 'hC001);
      rdc("R6 bank busy", 1, 2, 2, 'h0000);
      idle(70);
      rdc("R6 bank erase flags", 1, 0, 0, 'h00A2);
      wr(1, 0, 'hFF);
      rdc("R6 block 2 erased", 1, 2, 4, 'hFFFF);
      rdc("R6 block 3 erased", 1, 3, 7, 'hFFFF);
      rdc("R6 protected block kept", 1, 1, 4, 'hC02C);
      blk_prot = '0;

      cur_req = "R13";
      wr(0, 0, 'h20);
      wr(0, 0, 'hD0);
      idle(5);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rdc("R13 array after abort", 0, 0, 0, 'hC000);
      rdc("R1 pattern reloaded", 1, 2, 4, 'hC034);
      wr(0, 0, 'h70);
      rdc("R13 status after abort", 0, 0, 0, 'h0080);

      idle(3);
      finish_run();
   end

endmodule